// File: doc/BRIEF.md
# Serial Character Transmitter with Break Generation

This block is the transmit half of an asynchronous serial port. It is paced by a one-cycle bit-tick enable from an external baud generator. Each tick marks one bit time on the line. Software-side logic writes characters into a one-entry holding register. When the shift register goes idle, the character moves into it at the next tick and is sent as a start bit (0), the data least significant bit first, and a stop bit (1). The line rests high between characters. Characters are 8 bits wide. In nine-bit mode a ninth bit, taken from a separate write input, follows the eighth data bit.

The block can also send a break for single-wire master/slave buses: 13 bit times of low followed by one high stop bit. A one-cycle request arms the break, and the armed flag clears itself when the break's stop bit ends. Two flags leave the block. One says the holding register is empty and serves as the transmit interrupt request. The other says the shift register is idle. The pin is driven only when both the transmitter enable and the port enable are set.

Top module: `uart_break_tx`

## Requirements
- R1: After reset, tx_out is 1, tx_oe is 0, hold_empty is 1, shift_empty is 1 and brk_pend is 0.
- R2: With nine_bit low, a character goes out as one low start bit, 8 data bits least significant bit first, and one high stop bit. Each bit lasts exactly one bit-tick interval, and the line is high when idle.
- R3: With nine_bit high, the ninth bit (wr_bit9, captured with the write) goes out between data bit 7 and the stop bit, so the frame is 11 bit times.
- R4: A write (wr_stb high for one cycle) is accepted only when hold_empty is 1 and tx_en is 1. hold_empty reads 0 from the next cycle. A write while the holding register is full has no effect on the register or on the line.
- R5: A full holding register moves to the shift register on the first bit_tick at which the shifter is idle, or at which it is ending a stop bit. After that edge hold_empty is 1 and shift_empty is 0, so two queued characters go out back to back with no idle bit between them.
- R6: shift_empty is 0 from the tick that starts a frame until the tick that ends its stop bit.
- R7: A one-cycle brk_req sets brk_pend in the next cycle. At the next tick at which the shifter is free, the line goes low for 13 bit times and then high for one stop bit. brk_pend clears at the tick that ends that stop bit.
- R8: When a break is pending and the holding register is full, the break is sent first and the held character follows it.
- R9: tx_oe equals tx_en AND port_en, delayed by one register. While tx_oe is 0, tx_out is 1, but the shifter still runs and consumes characters.
- R10: Driving tx_en low empties the holding register, stops the shifter and cancels a pending break from the next cycle on. Writes made while tx_en is low are ignored.
- R11: tx_out shows each new bit one clock cycle after the tick edge that starts it, so a start bit appears on the pin two cycles after the tick is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse, once per bit time |
| tx_en | input | 1 | Transmitter enable; low flushes the transmitter |
| port_en | input | 1 | Port enable; gates the pin driver |
| nine_bit | input | 1 | Selects 9-bit characters |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character data |
| wr_bit9 | input | 1 | Ninth data bit, captured with the write |
| brk_req | input | 1 | One-cycle break request |
| tx_out | output | 1 | Serial line output |
| tx_oe | output | 1 | Pin output enable |
| hold_empty | output | 1 | Holding register empty (interrupt request) |
| shift_empty | output | 1 | Shift register idle |
| brk_pend | output | 1 | Break armed or in progress |

## Verification
The bench decodes every frame on the pin and compares it with a queue of expected characters and breaks. A wrong bit order, a missing ninth bit, or a break of the wrong length therefore shows up as a mismatched item. Back-to-back characters are timed start edge to start edge. A design that waits an extra tick before moving the held character would insert an idle bit there. A third write into a full register must not appear on the line, and a break requested while a character is held must come out ahead of that character. A design that overwrote the register or ignored the priority would reorder or corrupt the queue. Disabling the port while data is queued must keep the pin high while the shifter still drains. Dropping the transmitter enable must clear both flags and the armed break.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // What the shifter loads at a tick boundary
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_CHAR = 2'd1,
    LD_BRK  = 2'd2
  } load_e;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_b9,
  output logic              hold_full
);

  logic accept;

  // Writes only land in an empty register of an enabled transmitter
  assign accept = !flush && wr_stb && !hold_full;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hold_full <= 1'b0;
      hold_data <= '0;
      hold_b9   <= 1'b0;
    end else if (accept) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
      hold_b9   <= wr_bit9;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic brk_req,
  input  logic brk_done,
  output logic brk_pend
);

  // A new request wins over the completion of an earlier break
  always_ff @(posedge clk) begin
    if (rst || flush)  brk_pend <= 1'b0;
    else if (brk_req)  brk_pend <= 1'b1;
    else if (brk_done) brk_pend <= 1'b0;
  end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BRK_LEN = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              bit_tick,
  input  logic              nine_bit,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_b9,
  input  logic              brk_pend,
  output logic              take,
  output logic              brk_done,
  output logic              line,
  output logic              shift_empty
);

  localparam int FRAME_W = (BRK_LEN + 1 > DATA_W + 3) ? BRK_LEN + 1 : DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LEN_8 = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] LEN_9 = CNT_W'(DATA_W + 3);
  localparam logic [CNT_W-1:0] LEN_B = CNT_W'(BRK_LEN + 1);

  logic               busy_q;
  logic               brk_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sr_q;

  logic               finishing;
  logic               free;
  load_e              ld;
  logic [FRAME_W-1:0] char_frame;
  logic [FRAME_W-1:0] brk_frame;

  assign finishing = busy_q && bit_tick && (cnt_q == CNT_W'(1));
  assign free      = !busy_q || finishing;
  assign brk_done  = finishing && brk_q;

  // Break has priority over the held character
  always_comb begin
    ld = LD_NONE;
    if (bit_tick && free) begin
      if (brk_pend && !brk_done) ld = LD_BRK;
      else if (hold_full)        ld = LD_CHAR;
    end
  end

  assign take = (ld == LD_CHAR);

  always_comb begin
    char_frame             = '1;
    char_frame[0]          = 1'b0;
    char_frame[DATA_W:1]   = hold_data;
    if (nine_bit) char_frame[DATA_W+1] = hold_b9;
  end

  always_comb begin
    brk_frame              = '1;
    brk_frame[BRK_LEN-1:0] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy_q <= 1'b0;
      brk_q  <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '1;
    end else if (ld == LD_BRK) begin
      busy_q <= 1'b1;
      brk_q  <= 1'b1;
      cnt_q  <= LEN_B;
      sr_q   <= brk_frame;
    end else if (ld == LD_CHAR) begin
      busy_q <= 1'b1;
      brk_q  <= 1'b0;
      cnt_q  <= nine_bit ? LEN_9 : LEN_8;
      sr_q   <= char_frame;
    end else if (busy_q && bit_tick) begin
      if (finishing) begin
        busy_q <= 1'b0;
        brk_q  <= 1'b0;
      end
      cnt_q <= cnt_q - CNT_W'(1);
      sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
    end
  end

  assign line        = busy_q ? sr_q[0] : 1'b1;
  assign shift_empty = !busy_q;

endmodule

// File: rtl/uart_tx_pin.sv
module uart_tx_pin (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic port_en,
  input  logic line,
  output logic tx_out,
  output logic tx_oe
);

  logic drive;
  assign drive = tx_en && port_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_out <= 1'b1;
      tx_oe  <= 1'b0;
    end else begin
      tx_out <= drive ? line : 1'b1;
      tx_oe  <= drive;
    end
  end

endmodule

// File: rtl/uart_break_tx.sv
module uart_break_tx #(
  parameter int DATA_W  = 8,
  parameter int BRK_LEN = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              port_en,
  input  logic              nine_bit,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              brk_req,
  output logic              tx_out,
  output logic              tx_oe,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              brk_pend
);

  logic              flush;
  logic              take;
  logic              brk_done;
  logic              line;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              hold_b9;

  assign flush      = !tx_en;
  assign hold_empty = !hold_full;

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .wr_bit9   (wr_bit9),
    .take      (take),
    .hold_data (hold_data),
    .hold_b9   (hold_b9),
    .hold_full (hold_full)
  );

  uart_tx_brk u_brk (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .brk_req  (brk_req),
    .brk_done (brk_done),
    .brk_pend (brk_pend)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .BRK_LEN(BRK_LEN)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .bit_tick    (bit_tick),
    .nine_bit    (nine_bit),
    .hold_full   (hold_full),
    .hold_data   (hold_data),
    .hold_b9     (hold_b9),
    .brk_pend    (brk_pend),
    .take        (take),
    .brk_done    (brk_done),
    .line        (line),
    .shift_empty (shift_empty)
  );

  uart_tx_pin u_pin (
    .clk     (clk),
    .rst     (rst),
    .tx_en   (tx_en),
    .port_en (port_en),
    .line    (line),
    .tx_out  (tx_out),
    .tx_oe   (tx_oe)
  );

endmodule

// File: rtl/uart_break_tx_chk.sv
module uart_break_tx_chk (
  input logic clk,
  input logic rst,
  input logic bit_tick,
  input logic tx_en,
  input logic port_en,
  input logic wr_stb,
  input logic brk_req,
  input logic tx_out,
  input logic tx_oe,
  input logic hold_empty,
  input logic shift_empty,
  input logic brk_pend
);

  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_en || !port_en) |=> !tx_oe);

  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_oe |-> tx_out);

  // R4
  hold_fill_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_empty) |-> $past(wr_stb && tx_en));

  // R5
  load_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(shift_empty) |-> $past(bit_tick));

  // R5
  take_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && bit_tick && shift_empty && (!hold_empty || brk_pend)) |=> !shift_empty);

  // R7
  brk_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_pend) |-> $past(brk_req));

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (hold_empty && shift_empty && !brk_pend));

  // R11
  low_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_out |-> !$past(shift_empty));

endmodule

bind uart_break_tx uart_break_tx_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .bit_tick    (bit_tick),
  .tx_en       (tx_en),
  .port_en     (port_en),
  .wr_stb      (wr_stb),
  .brk_req     (brk_req),
  .tx_out      (tx_out),
  .tx_oe       (tx_oe),
  .hold_empty  (hold_empty),
  .shift_empty (shift_empty),
  .brk_pend    (brk_pend)
);

// File: tb/uart_break_tx_tb.sv
module uart_break_tx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam logic [9:0] BRK_ITEM = 10'h200;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_tick = 1'b0;
  logic       tx_en = 1'b0;
  logic       port_en = 1'b0;
  logic       nine_bit = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_bit9 = 1'b0;
  logic       brk_req = 1'b0;
  logic       tx_out;
  logic       tx_oe;
  logic       hold_empty;
  logic       shift_empty;
  logic       brk_pend;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit done     = 1'b0;
  bit mon_busy = 1'b0;
  logic [9:0] exp_q[$];
  int starts[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_break_tx u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_en(tx_en), .port_en(port_en),
    .nine_bit(nine_bit), .wr_stb(wr_stb), .wr_data(wr_data), .wr_bit9(wr_bit9),
    .brk_req(brk_req), .tx_out(tx_out), .tx_oe(tx_oe), .hold_empty(hold_empty),
    .shift_empty(shift_empty), .brk_pend(brk_pend)
  );

  // Bit-tick source, updated after the edge so the design sees a stable value
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (rst) cnt = 0;
      else cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
      bit_tick <= !rst && (cnt == TICK_DIV - 1);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic b9);
    wr_stb = 1'b1; wr_data = d; wr_bit9 = b9;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic b9);
    int guard = 0;
    while (!hold_empty && guard < 1000) begin @(negedge clk); guard++; end
    exp_q.push_back({1'b0, nine_bit ? b9 : 1'b0, d});
    wr(d, b9);
  endtask

  task automatic pulse_brk();
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
  endtask

  task automatic wait_tick();
    while (!bit_tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while ((exp_q.size() != 0 || mon_busy || !shift_empty || !hold_empty) && guard < 3000) begin
      @(negedge clk); guard++;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0 && !mon_busy, req, exp_q.size(), 0);
  endtask

  // Monitor: decodes frames from the pin and scores them against the queue
  initial begin
    forever begin
      @(negedge clk);
      if (tx_oe && !tx_out) begin
        int n;
        int lows;
        logic [8:0] d;
        logic stopb;
        logic [9:0] got;
        mon_busy = 1'b1;
        starts.push_back(cyc);
        n = nine_bit ? 9 : 8;
        d = '0;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
          repeat (TICK_DIV) @(negedge clk);
          d[i] = tx_out;
        end
        repeat (TICK_DIV) @(negedge clk);
        stopb = tx_out;
        if (stopb) begin
          got = (n == 9) ? {1'b0, d} : {2'b00, d[7:0]};
        end else begin
          lows = n + 2;
          for (int g = 0; g < 20; g++) begin
            repeat (TICK_DIV) @(negedge clk);
            if (tx_out) break;
            lows++;
          end
          got = (d == '0 && lows == 13) ? BRK_ITEM : 10'h3FF;
        end
        if (exp_q.size() == 0) begin
          check(1'b0, "R2/R4 unexpected frame", got, 0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check(got == e, (e == BRK_ITEM) ? "R7 break frame" : (nine_bit ? "R3 frame" : "R2 frame"), got, e);
        end
        mon_busy = 1'b0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(tx_out == 1'b1, "R1 tx_out", tx_out, 1);
    check(tx_oe == 1'b0, "R1 tx_oe", tx_oe, 0);
    check(hold_empty && shift_empty && !brk_pend, "R1 flags",
          {hold_empty, shift_empty, brk_pend}, 3'b110);

    tx_en = 1'b1; port_en = 1'b1;
    @(negedge clk);
    check(tx_oe == 1'b1, "R9 oe on", tx_oe, 1);
    repeat (8) @(negedge clk);

    // R4/R5/R11: first character, exact timing
    send(8'hA5, 1'b0);
    check(hold_empty == 1'b0, "R4 hold full after write", hold_empty, 0);
    wait_tick();
    check(hold_empty && !shift_empty, "R5 move on tick", {hold_empty, shift_empty}, 2'b10);
    check(tx_out == 1'b1, "R11 pin one cycle late", tx_out, 1);
    @(negedge clk);
    check(tx_out == 1'b0, "R11 start bit on pin", tx_out, 0);
    // R5 back to back, R4 write while full ignored
    send(8'h3C, 1'b0);
    wr(8'h77, 1'b0);
    check(hold_empty == 1'b0, "R4 full write ignored", hold_empty, 0);
    drain("R4 queue drained");
    check(starts.size() >= 2 && (starts[1] - starts[0]) == 10 * TICK_DIV, "R5 no gap",
          starts.size() >= 2 ? starts[1] - starts[0] : -1, 10 * TICK_DIV);
    // R6: shift_empty held low across a frame
    send(8'h00, 1'b0);
    wait_tick();
    begin
      bit ok = 1'b1;
      for (int i = 0; i < 9 * TICK_DIV; i++) begin
        if (shift_empty) ok = 1'b0;
        @(negedge clk);
      end
      check(ok, "R6 busy through frame", ok, 1);
    end
    send(8'hFF, 1'b0);
    drain("R2 patterns");

    // R3: nine-bit characters
    nine_bit = 1'b1;
    send(8'h55, 1'b1);
    send(8'hAA, 1'b0);
    send(8'h01, 1'b1);
    drain("R3 patterns");
    nine_bit = 1'b0;

    // R7: break alone
    pulse_brk();
    check(brk_pend == 1'b1, "R7 armed", brk_pend, 1);
    exp_q.push_back(BRK_ITEM);
    begin
      int t = 0;
      while (brk_pend && t < 20 * TICK_DIV) begin @(negedge clk); t++; end
      check(!brk_pend && shift_empty, "R7 self clear", {brk_pend, shift_empty}, 2'b01);
      check(t >= 14 * TICK_DIV && t <= 15 * TICK_DIV + 2, "R7 break duration", t, 14 * TICK_DIV);
    end
    drain("R7 break");

    // R8: break ahead of held character
    send(8'h81, 1'b0);
    wait_tick();
    wr(8'h42, 1'b0);
    pulse_brk();
    exp_q.push_back(BRK_ITEM);
    exp_q.push_back(10'h042);
    drain("R8 priority");

    // R9: port disabled, shifter still drains
    port_en = 1'b0;
    @(negedge clk);
    check(tx_oe == 1'b0, "R9 oe off", tx_oe, 0);
    wr(8'h00, 1'b0);
    begin
      bit quiet = 1'b1;
      bit ran = 1'b0;
      for (int i = 0; i < 12 * TICK_DIV; i++) begin
        if (!tx_out || tx_oe) quiet = 1'b0;
        if (!shift_empty) ran = 1'b1;
        @(negedge clk);
      end
      check(quiet, "R9 pin held high", quiet, 1);
      check(ran, "R9 shifter ran", ran, 1);
    end

    // R10: flush with enable low
    wait_tick();
    wr(8'h11, 1'b0);
    wait_tick();
    wr(8'h22, 1'b0);
    pulse_brk();
    check(!hold_empty && !shift_empty && brk_pend, "R10 loaded before flush",
          {hold_empty, shift_empty, brk_pend}, 3'b001);
    tx_en = 1'b0;
    @(negedge clk);
    check(hold_empty && shift_empty && !brk_pend, "R10 flushed",
          {hold_empty, shift_empty, brk_pend}, 3'b110);
    wr(8'h33, 1'b0);
    @(negedge clk);
    check(hold_empty == 1'b1, "R10 write ignored when disabled", hold_empty, 1);

    // Recovery after re-enable
    tx_en = 1'b1; port_en = 1'b1;
    repeat (3) @(negedge clk);
    send(8'hC3, 1'b0);
    drain("R2 after re-enable");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule